// File: doc/BRIEF.md
# Clickless Mute Volume Ramp

This block sits in an audio sample path and multiplies every valid sample by a gain that never jumps. The gain moves toward a target one fixed step per valid sample. While mute is requested the target is zero. Otherwise the target is the programmed volume word. Engaging mute therefore fades the signal out along a linear ramp, and releasing it fades the signal back in to the programmed level. A change of volume while unmuted follows the same ramp.

The gain is unsigned with 14 fractional bits, so 16384 is unity (0 dB). The default step of 35 takes unity to zero in 469 samples, which is just under 10 ms at 48 kHz. The product is rounded and clamped to the sample width and then registered. A status output reports when the gain has reached its current target.

Top module: `mute_ramp_gain`

## Requirements
- R1: The effective mute request is the logical OR of `mute_pin` and `mute_sw`. Either input alone mutes.
- R2: While mute is requested, each valid sample lowers the gain by STEP, or to exactly zero if the gain is below STEP. The gain never goes below zero.
- R3: While unmuted, each valid sample moves the gain toward `vol` by STEP and stops exactly at `vol`. This holds for both rising and falling changes of `vol`.
- R4: The gain changes only on a cycle where `smp_vld` is 1.
- R5: A mute request that starts or ends partway through a ramp reverses the ramp from the current gain. Two successive gains never differ by more than STEP.
- R6: One cycle after `smp_vld` is sampled high, `out_vld` is 1 and `smp_out` equals floor((sample × gain + 8192) / 16384), using the gain in effect before that sample's step. The result is clamped to the signed SAMPLE_W range. `smp_out` holds its value on cycles with no valid input.
- R7: When the gain applied to a sample is zero, the output for that sample is exactly zero.
- R8: `settled` is 1 exactly when the current gain equals the current target (0 when muted, `vol` when unmuted).
- R9: Reset sets the gain, `smp_out` and `out_vld` to zero.
- R10: With default parameters, a mute from unity reaches zero gain after 469 valid samples, which is no more than 480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Input sample strobe |
| smp_in | input | SAMPLE_W | Signed input sample |
| vol | input | GAIN_W | Programmed volume (unity = 16384) |
| mute_pin | input | 1 | Hardware mute request |
| mute_sw | input | 1 | Software mute request |
| smp_out | output | SAMPLE_W | Scaled, rounded, clamped sample |
| out_vld | output | 1 | Output sample strobe |
| settled | output | 1 | Gain equals current target |

## Verification
A scaled sample is due one clock after its strobe is sampled, and it uses the gain from before that strobe's step. The stepped gain is due in the same edge, so it first shows in the next sample's product. `settled` is combinational from the registered gain and the live target, so it is due together with the gain. The bench changes inputs only before a rising edge and samples 1 ns after it. Its reference model takes each strobe, applies the old gain and then steps, so every comparison matches these latencies.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } ramp_dir_e;
endpackage

// File: rtl/mrg_ramp_ctrl.sv
module mrg_ramp_ctrl
    import mrg_pkg::*;
#(
    parameter int GAIN_W = 16,
    parameter int STEP   = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic              mute_req,
    input  logic [GAIN_W-1:0] vol,
    output logic [GAIN_W-1:0] gain,
    output logic              settled
);
    localparam int EW = GAIN_W + 1;
    localparam logic [EW-1:0] STEP_E = EW'(STEP);

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
    } ramp_st_t;

    ramp_st_t  st_d, st_q;
    ramp_dir_e dir;
    logic [GAIN_W-1:0] target;
    logic [EW-1:0]     up_e, tgt_e, cur_e;

    always_comb begin
        st_d   = st_q;
        target = mute_req ? '0 : vol;
        cur_e  = {1'b0, st_q.gain};
        tgt_e  = {1'b0, target};
        up_e   = cur_e + STEP_E;
        if (st_q.gain < target)      dir = DIR_UP;
        else if (st_q.gain > target) dir = DIR_DOWN;
        else                         dir = DIR_HOLD;
        if (step_en) begin
            unique case (dir)
                DIR_UP:   st_d.gain = (up_e >= tgt_e) ? target : up_e[GAIN_W-1:0];
                DIR_DOWN: st_d.gain = (cur_e <= tgt_e + STEP_E) ? target
                                    : GAIN_W'(cur_e - STEP_E);
                default:  st_d.gain = st_q.gain;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gain    = st_q.gain;
    assign settled = (st_q.gain == target);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(gain));
    p_mute_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_req && step_en && gain != '0) |=> gain < $past(gain));
    p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> ((gain >= $past(gain)) ? ((gain - $past(gain)) <= GAIN_W'(STEP))
                                          : (($past(gain) - gain) <= GAIN_W'(STEP))));
    p_unmute_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mute_req && step_en && gain < vol) |=> gain <= $past(vol));
endmodule

// File: rtl/mrg_gain_mult.sv
module mrg_gain_mult #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 16,
    parameter int FRAC     = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    input  logic        [GAIN_W-1:0]   gain_i,
    output logic signed [SAMPLE_W-1:0] smp_o,
    output logic                       vld_o
);
    localparam int RW = SAMPLE_W + GAIN_W + 2;
    localparam logic signed [RW-1:0] HALF = RW'(1) << (FRAC - 1);
    localparam logic signed [RW-1:0] MAXV = (RW'(1) << (SAMPLE_W - 1)) - RW'(1);
    localparam logic signed [RW-1:0] MINV = -(RW'(1) << (SAMPLE_W - 1));

    typedef struct packed {
        logic                vld;
        logic [SAMPLE_W-1:0] data;
    } mult_st_t;

    mult_st_t st_d, st_q;
    logic signed [RW-1:0] prod_w, rnd_w, shr_w;

    always_comb begin
        st_d     = st_q;
        prod_w   = RW'(smp_i) * $signed({2'b00, gain_i});
        rnd_w    = prod_w + HALF;
        shr_w    = rnd_w >>> FRAC;
        st_d.vld = in_vld;
        if (in_vld) begin
            if (shr_w > MAXV)      st_d.data = MAXV[SAMPLE_W-1:0];
            else if (shr_w < MINV) st_d.data = MINV[SAMPLE_W-1:0];
            else                   st_d.data = shr_w[SAMPLE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o = $signed(st_q.data);
    assign vld_o = st_q.vld;

    p_zero_gain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && gain_i == '0) |=> (smp_o == '0));
    p_out_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> vld_o);
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!vld_o && $stable(smp_o)));
endmodule

// File: rtl/mute_ramp_gain.sv
module mute_ramp_gain #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 16,
    parameter int FRAC     = 14,
    parameter int STEP     = 35
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp_in,
    input  logic        [GAIN_W-1:0]   vol,
    input  logic                       mute_pin,
    input  logic                       mute_sw,
    output logic signed [SAMPLE_W-1:0] smp_out,
    output logic                       out_vld,
    output logic                       settled
);
    logic              mute_req;
    logic [GAIN_W-1:0] gain_w;

    assign mute_req = mute_pin | mute_sw;

    mrg_ramp_ctrl #(.GAIN_W(GAIN_W), .STEP(STEP)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (smp_vld),
        .mute_req(mute_req),
        .vol     (vol),
        .gain    (gain_w),
        .settled (settled)
    );

    mrg_gain_mult #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_mult (
        .clk   (clk),
        .rst_n (rst_n),
        .in_vld(smp_vld),
        .smp_i (smp_in),
        .gain_i(gain_w),
        .smp_o (smp_out),
        .vld_o (out_vld)
    );

    p_either_mute_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((mute_pin ^ mute_sw) && smp_vld && gain_w != '0) |=> gain_w < $past(gain_w));
endmodule

// File: tb/mute_ramp_gain_tb.sv
module mute_ramp_gain_tb;
    localparam int SW = 24;
    localparam int GW = 16;
    localparam int STEP = 35;

    logic clk = 0, rst_n = 0, vld = 0, pin = 0, sw = 0;
    logic signed [SW-1:0] din = '0;
    logic [GW-1:0] vol = 16'd16384;
    logic signed [SW-1:0] dout;
    logic ov, settled;

    int n_vec = 0, n_bad = 0;
    longint g = 0;
    longint exp_out = 0;
    bit exp_ov = 0;
    int unsigned lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    mute_ramp_gain u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(vld), .smp_in(din), .vol(vol),
        .mute_pin(pin), .mute_sw(sw), .smp_out(dout), .out_vld(ov), .settled(settled)
    );

    function automatic longint scale(longint s, longint gg);
        longint r;
        r = (s * gg + 8192) >>> 14;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input longint s, input string tag);
        longint tgt;
        vld = v; din = SW'(s);
        @(posedge clk); #1;
        tgt = (pin | sw) ? 0 : longint'(vol);
        exp_ov = v;
        if (v) begin
            exp_out = scale(s, g);
            if (g < tgt) g = (g + STEP >= tgt) ? tgt : g + STEP;
            else if (g > tgt) g = (g <= tgt + STEP) ? tgt : g - STEP;
        end
        chk(ov == exp_ov, {tag, " out_vld R6"}, ov, exp_ov);
        chk(longint'(dout) == exp_out, {tag, " smp_out R6"}, dout, exp_out);
        chk(settled == (g == tgt), {tag, " settled R8"}, settled, g == tgt);
    endtask

    function automatic longint rnd_smp();
        lcg = lcg * 1103515245 + 12345;
        return longint'($signed(lcg[31:8])) ;
    endfunction

    initial begin
        int cnt;
        repeat (3) @(posedge clk);
        #1;
        chk(dout == 0, "reset smp_out R9", dout, 0);
        chk(ov == 0, "reset out_vld R9", ov, 0);
        rst_n = 1;
        // R3 ramp up from zero to unity, continuous strobes
        for (int i = 0; i < 500; i++) step(1, rnd_smp(), "rampup R3");
        // R4 sparse strobes, gain holds between them
        for (int i = 0; i < 40; i++) step(i % 3 == 0, rnd_smp(), "sparse R4");
        // R2 R10 hardware mute from unity, count to settle
        pin = 1; cnt = 0;
        for (int i = 0; i < 600; i++) begin
            step(1, rnd_smp(), "pin mute R2");
            if (!settled) cnt++;
        end
        chk(cnt + 1 == 469 && cnt + 1 <= 480, "ramp length R10", cnt + 1, 469);
        // R7 zero gain gives exact zero even at full scale
        for (int i = 0; i < 5; i++) step(1, (i % 2) ? -8388608 : 8388607, "zero gain R7");
        chk(dout == 0, "zero gain R7", dout, 0);
        // R5 reversal mid-ramp, R1 software bit alone
        pin = 0;
        for (int i = 0; i < 100; i++) step(1, rnd_smp(), "unmute R3");
        sw = 1;
        for (int i = 0; i < 50; i++) step(1, rnd_smp(), "sw mute R1");
        sw = 0;
        for (int i = 0; i < 30; i++) step(1, rnd_smp(), "reverse R5");
        pin = 1; sw = 1;
        for (int i = 0; i < 20; i++) step(1, rnd_smp(), "both mute R1");
        pin = 0; sw = 0;
        for (int i = 0; i < 500; i++) step(1, rnd_smp(), "re-unmute R5");
        // R3 volume down then up while unmuted
        vol = 16'd8000;
        for (int i = 0; i < 300; i++) step(1, rnd_smp(), "vol down R3");
        vol = 16'hFFFF;
        for (int i = 0; i < 1500; i++) step(1, rnd_smp(), "vol up R3");
        // R6 saturation both signs
        for (int i = 0; i < 10; i++) step(1, 8000000, "sat pos R6");
        chk(dout == 24'sd8388607, "sat pos R6", dout, 8388607);
        for (int i = 0; i < 10; i++) step(1, -8000000, "sat neg R6");
        chk(dout == -24'sd8388608, "sat neg R6", dout, -8388608);
        step(0, 0, "idle hold R6");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule